// File: doc/BRIEF.md
# Unified Data-Space Access Router

This block sits between the load/store stage of a small 8-bit core and everything a byte access can reach. The core presents one byte-wide address in a flat data space. The router decides whether that address names a general-purpose register, one of eight core-owned special ports, a peripheral port, or plain data memory. It then steers the read or write to that target and returns the read byte.

The lowest 32 addresses select the general register file, which lives outside this block. The next 64 addresses form an I/O window. The eight highest ports of that window are served inside the router:

- four data-page extension registers;
- a jump-page extension register;
- the two halves of the stack pointer;
- a pass-through port to the status register.

Each extension register keeps one byte and presents it to the core already shifted up into bits 23:16 of a 24-bit value. Four strap inputs allow or block writes to the data-page registers. A fifth strap allows or blocks writes to the stack pointer high byte.

The remaining I/O ports and all higher addresses go to an external byte bus. That bus has a request/ready handshake, and the router stalls the core until ready arrives. Accesses that stay inside the core finish in the cycle they are presented.

Top module: `dspace_router`

## Requirements
- R1: An access with address below 32 targets the general register file at index address[4:0]. A write asserts `gpr_we` with the masked byte. A read returns `gpr_rdata`. No memory request is raised.
- R2: An address from 32 to 87 is I/O port p = address - 32 (p from 0 to 55). It raises a memory request at `IO_BASE + p`, with `mem_we` equal to the access direction.
- R3: An address of 96 or above raises a memory request at `DATA_BASE + address`.
- R4: Ports 56, 57, 58 and 59 (addresses 88 to 91) are data-page registers D, X, Y and Z. A write stores the byte only if strap bit 0, 1, 2 or 3 respectively is 1; otherwise the register keeps its value. The register appears on its output in bits 23:16, with bits 15:0 zero. A read returns the stored byte whatever the straps are.
- R5: Port 60 (address 92) is the jump-page register. Writes always take effect. Reads and output placement are as in R4.
- R6: Port 61 (address 93) writes the stack pointer low byte and leaves the high byte unchanged. A read returns the low byte.
- R7: Port 62 (address 94) reads the stack pointer high byte. A write changes it only when strap bit 4 is 1.
- R8: Port 63 (address 95) reads `sreg_rdata`. A write pulses `sreg_we` with the byte on `sreg_wdata`. `sreg_we` is low in every other case.
- R9: Only bits 7:0 of `core_wdata` are used. Bits 15:8 never reach any register, output or bus.
- R10: While a memory request is pending and `mem_ready` is low, `core_stall` is high and `core_done` is low. In the cycle `mem_ready` is high, `core_done` is high, `core_stall` is low, and a read returns `mem_rdata`.
- R11: After reset the five extension registers are zero and the stack pointer equals `SP_INIT` (default 16'h00FF).
- R12: An access to a general register or a special port finishes in the same cycle: `core_done` high, no stall, no memory request. Writes are visible on the outputs after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| core_req | input | 1 | Core presents a byte access |
| core_we | input | 1 | 1 = write, 0 = read |
| core_addr | input | 16 | Unified data-space address |
| core_wdata | input | 16 | Write data; only bits 7:0 are used |
| core_rdata | output | 8 | Read byte for the current access |
| core_done | output | 1 | Access completes this cycle |
| core_stall | output | 1 | Core must hold the access |
| feat_straps | input | 5 | Write enables: bits 3:0 data pages D/X/Y/Z, bit 4 stack pointer high byte |
| gpr_idx | output | 5 | General register index |
| gpr_we | output | 1 | General register write strobe |
| gpr_wdata | output | 8 | General register write byte |
| gpr_rdata | input | 8 | General register read byte |
| sreg_rdata | input | 8 | Packed status register value |
| sreg_we | output | 1 | Status register write strobe |
| sreg_wdata | output | 8 | Status register byte to unpack |
| mem_req | output | 1 | External bus request |
| mem_we | output | 1 | External bus write |
| mem_addr | output | 24 | External bus byte address |
| mem_wdata | output | 8 | External bus write byte |
| mem_rdata | input | 8 | External bus read byte |
| mem_ready | input | 1 | External bus completes this cycle |
| page_d_o | output | 24 | Data-page D extension, byte in 23:16 |
| page_x_o | output | 24 | Data-page X extension, byte in 23:16 |
| page_y_o | output | 24 | Data-page Y extension, byte in 23:16 |
| page_z_o | output | 24 | Data-page Z extension, byte in 23:16 |
| jump_page_o | output | 24 | Jump-page extension, byte in 23:16 |
| sp_o | output | 16 | Stack pointer |

## Verification
The bench sweeps every window boundary: addresses 31/32, 87/88, 95/96 and the top of the space. A decoder that is off by one would send a special port to the bus, or a peripheral port to a register, and the address or read byte would not match. Writes are repeated with each strap cleared and then set. A design that ignores a strap, or gates the jump page, leaves a register value that disagrees with the model. Writes to the stack pointer low byte and high byte are checked against each other, which catches a write that clobbers the wrong half. Bus accesses use ready delays of zero to three cycles, so that a design that finishes early or stalls too long is caught. Write data carries junk in its upper byte, so that a missing 8-bit mask shows up.

// File: rtl/dsr_pkg.sv
package dsr_pkg;

  localparam int unsigned NREG     = 32;
  localparam int unsigned NIO      = 64;
  localparam int unsigned NEXT     = 5;
  localparam int unsigned NSPEC    = 8;
  localparam int unsigned SPEC_LO  = NIO - NSPEC;
  localparam int unsigned PORT_W   = $clog2(NIO);
  localparam int unsigned SEL_W    = $clog2(NSPEC);

  typedef enum logic [1:0] {
    RGN_GPR   = 2'd0,
    RGN_SPEC  = 2'd1,
    RGN_IOMEM = 2'd2,
    RGN_DATA  = 2'd3
  } region_e;

  localparam logic [SEL_W-1:0] SEL_JUMP = 3'd4;
  localparam logic [SEL_W-1:0] SEL_SPL  = 3'd5;
  localparam logic [SEL_W-1:0] SEL_SPH  = 3'd6;
  localparam logic [SEL_W-1:0] SEL_SREG = 3'd7;

  function automatic region_e classify(input logic [31:0] a);
    region_e r;
    if (a < NREG)                r = RGN_GPR;
    else if (a < NREG + SPEC_LO) r = RGN_IOMEM;
    else if (a < NREG + NIO)     r = RGN_SPEC;
    else                         r = RGN_DATA;
    return r;
  endfunction

  function automatic logic [23:0] place_ext(input logic [7:0] b);
    return {b, 16'h0000};
  endfunction

  function automatic logic [23:0] bus_target(input region_e r,
                                             input logic [PORT_W-1:0] port,
                                             input logic [31:0] a,
                                             input logic [23:0] io_base,
                                             input logic [23:0] data_base);
    logic [23:0] t;
    if (r == RGN_IOMEM) t = io_base + 24'(port);
    else                t = data_base + a[23:0];
    return t;
  endfunction

endpackage

// File: rtl/dsr_decode.sv
module dsr_decode
  import dsr_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           rgn,
  output logic [PORT_W-1:0] port,
  output logic [SEL_W-1:0]  sel,
  output logic [31:0]       addr_ext
);

  assign addr_ext = 32'(addr);
  assign rgn      = classify(addr_ext);
  assign port     = PORT_W'(addr_ext - 32'(NREG));
  assign sel      = port[SEL_W-1:0];

endmodule

// File: rtl/dsr_core_regs.sv
module dsr_core_regs
  import dsr_pkg::*;
#(
  parameter logic [15:0] SP_INIT = 16'h00FF
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [SEL_W-1:0]          sel,
  input  logic [7:0]                wbyte,
  input  logic [NEXT:0]             straps,
  input  logic [7:0]                sreg_rdata,
  output logic [NEXT-1:0][23:0]     ext_q,
  output logic [15:0]               sp_q,
  output logic [7:0]                rd_byte,
  output logic                      sreg_we,
  output logic [7:0]                sreg_wdata
);

  logic [NEXT-1:0][7:0] ext_b;

  for (genvar g = 0; g < NEXT; g++) begin : g_ext
    logic [7:0] q;
    logic       en;
    if (g == NEXT - 1) begin : g_free
      assign en = 1'b1;
    end else begin : g_gated
      assign en = straps[g];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                     q <= 8'h00;
      else if (wr_en && sel == SEL_W'(g) && en)       q <= wbyte;
    end
    assign ext_b[g] = q;
    assign ext_q[g] = place_ext(q);
  end

  logic wide_sp;
  assign wide_sp = straps[NEXT-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q <= SP_INIT;
    end else if (wr_en) begin
      if (sel == SEL_SPL)                 sp_q[7:0]  <= wbyte;
      else if (sel == SEL_SPH && wide_sp) sp_q[15:8] <= wbyte;
    end
  end

  always_comb begin
    case (sel)
      SEL_SPL:  rd_byte = sp_q[7:0];
      SEL_SPH:  rd_byte = sp_q[15:8];
      SEL_SREG: rd_byte = sreg_rdata;
      default:  rd_byte = ext_b[sel[2:0] < 3'(NEXT) ? sel : '0];
    endcase
  end

  assign sreg_we    = wr_en && (sel == SEL_SREG);
  assign sreg_wdata = wbyte;

endmodule

// File: rtl/dsr_bus_port.sv
module dsr_bus_port
  import dsr_pkg::*;
#(
  parameter logic [23:0] IO_BASE   = 24'h80_0020,
  parameter logic [23:0] DATA_BASE = 24'h80_0000
) (
  input  logic               req,
  input  logic               we,
  input  region_e            rgn,
  input  logic [PORT_W-1:0]  port,
  input  logic [31:0]        addr_ext,
  input  logic [7:0]         wbyte,
  input  logic               mem_ready,
  output logic               mem_req,
  output logic               mem_we,
  output logic [23:0]        mem_addr,
  output logic [7:0]         mem_wdata,
  output logic               wait_bus
);

  logic to_bus;
  assign to_bus    = (rgn == RGN_IOMEM) || (rgn == RGN_DATA);
  assign mem_req   = req && to_bus;
  assign mem_we    = mem_req && we;
  assign mem_addr  = bus_target(rgn, port, addr_ext, IO_BASE, DATA_BASE);
  assign mem_wdata = wbyte;
  assign wait_bus  = mem_req && !mem_ready;

endmodule

// File: rtl/dspace_router.sv
module dspace_router
  import dsr_pkg::*;
#(
  parameter logic [23:0] IO_BASE   = 24'h80_0020,
  parameter logic [23:0] DATA_BASE = 24'h80_0000,
  parameter logic [15:0] SP_INIT   = 16'h00FF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        core_req,
  input  logic        core_we,
  input  logic [15:0] core_addr,
  input  logic [15:0] core_wdata,
  output logic [7:0]  core_rdata,
  output logic        core_done,
  output logic        core_stall,
  input  logic [4:0]  feat_straps,
  output logic [4:0]  gpr_idx,
  output logic        gpr_we,
  output logic [7:0]  gpr_wdata,
  input  logic [7:0]  gpr_rdata,
  input  logic [7:0]  sreg_rdata,
  output logic        sreg_we,
  output logic [7:0]  sreg_wdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [23:0] mem_addr,
  output logic [7:0]  mem_wdata,
  input  logic [7:0]  mem_rdata,
  input  logic        mem_ready,
  output logic [23:0] page_d_o,
  output logic [23:0] page_x_o,
  output logic [23:0] page_y_o,
  output logic [23:0] page_z_o,
  output logic [23:0] jump_page_o,
  output logic [15:0] sp_o
);

  region_e            rgn;
  logic [PORT_W-1:0]  port;
  logic [SEL_W-1:0]   spec_sel;
  logic [31:0]        addr_ext;
  logic [7:0]         wbyte;
  logic [7:0]         unused_wd_hi;
  logic               acc_gpr, acc_spec, acc_mem, spec_wr;
  logic [7:0]         spec_rd;
  logic [NEXT-1:0][23:0] ext_q;

  assign wbyte        = core_wdata[7:0];
  assign unused_wd_hi = core_wdata[15:8];

  dsr_decode #(.ADDR_W(16)) u_dec (
    .addr     (core_addr),
    .rgn      (rgn),
    .port     (port),
    .sel      (spec_sel),
    .addr_ext (addr_ext)
  );

  assign acc_gpr  = core_req && (rgn == RGN_GPR);
  assign acc_spec = core_req && (rgn == RGN_SPEC);
  assign acc_mem  = core_req && (rgn == RGN_IOMEM || rgn == RGN_DATA);
  assign spec_wr  = acc_spec && core_we;

  dsr_core_regs #(.SP_INIT(SP_INIT)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (spec_wr),
    .sel        (spec_sel),
    .wbyte      (wbyte),
    .straps     (feat_straps),
    .sreg_rdata (sreg_rdata),
    .ext_q      (ext_q),
    .sp_q       (sp_o),
    .rd_byte    (spec_rd),
    .sreg_we    (sreg_we),
    .sreg_wdata (sreg_wdata)
  );

  logic wait_bus;

  dsr_bus_port #(.IO_BASE(IO_BASE), .DATA_BASE(DATA_BASE)) u_bus (
    .req       (core_req),
    .we        (core_we),
    .rgn       (rgn),
    .port      (port),
    .addr_ext  (addr_ext),
    .wbyte     (wbyte),
    .mem_ready (mem_ready),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .wait_bus  (wait_bus)
  );

  assign gpr_idx   = core_addr[4:0];
  assign gpr_we    = acc_gpr && core_we;
  assign gpr_wdata = wbyte;

  always_comb begin
    if (acc_gpr)       core_rdata = gpr_rdata;
    else if (acc_spec) core_rdata = spec_rd;
    else               core_rdata = mem_rdata;
  end

  assign core_stall = wait_bus;
  assign core_done  = core_req && !wait_bus;

  assign page_d_o    = ext_q[0];
  assign page_x_o    = ext_q[1];
  assign page_y_o    = ext_q[2];
  assign page_z_o    = ext_q[3];
  assign jump_page_o = ext_q[4];

endmodule

// File: rtl/dspace_router_chk.sv
module dspace_router_chk (
  input logic             clk,
  input logic             rst_n,
  input logic             core_req,
  input logic             acc_gpr,
  input logic             acc_mem,
  input logic             mem_req,
  input logic             mem_ready,
  input logic             core_stall,
  input logic             core_done,
  input logic             spec_wr,
  input logic [2:0]       spec_sel,
  input logic [7:0]       wbyte,
  input logic [4:0]       straps,
  input logic [4:0][23:0] ext_q,
  input logic [15:0]      sp_o,
  input logic             sreg_we
);

  AST_GPR_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    acc_gpr |-> !mem_req); // R1

  AST_STALL_UNTIL_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |-> (core_stall && !core_done)); // R10

  AST_READY_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ready) |-> (core_done && !core_stall)); // R10

  AST_INTERNAL_NO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (core_req && !acc_mem) |-> (core_done && !core_stall && !mem_req)); // R12

  AST_PAGE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (spec_wr && !spec_sel[2] && !straps[spec_sel[1:0]]) |=> $stable(ext_q)); // R4

  AST_JUMP_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (spec_wr && spec_sel == 3'd4) |=> (ext_q[4][23:16] == $past(wbyte))); // R5

  AST_SPL_KEEPS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (spec_wr && spec_sel == 3'd5) |=>
      (sp_o[15:8] == $past(sp_o[15:8]) && sp_o[7:0] == $past(wbyte))); // R6

  AST_SPH_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (spec_wr && spec_sel == 3'd6 && !straps[4]) |=> $stable(sp_o)); // R7

  AST_SREG_STROBE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    sreg_we |-> (spec_wr && spec_sel == 3'd7)); // R8

endmodule

bind dspace_router dspace_router_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .core_req   (core_req),
  .acc_gpr    (acc_gpr),
  .acc_mem    (acc_mem),
  .mem_req    (mem_req),
  .mem_ready  (mem_ready),
  .core_stall (core_stall),
  .core_done  (core_done),
  .spec_wr    (spec_wr),
  .spec_sel   (spec_sel),
  .wbyte      (wbyte),
  .straps     (feat_straps),
  .ext_q      (ext_q),
  .sp_o       (sp_o),
  .sreg_we    (sreg_we)
);

// File: tb/dspace_router_tb_top.sv
module dspace_router_tb_top;

  localparam logic [23:0] IO_B   = 24'h80_0020;
  localparam logic [23:0] DATA_B = 24'h80_0000;
  localparam logic [15:0] SP0    = 16'h00FF;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        core_req = 0, core_we = 0, mem_ready = 0;
  logic [15:0] core_addr = 0, core_wdata = 0;
  logic [4:0]  feat_straps = 0;
  logic [7:0]  sreg_rdata = 0;
  logic [7:0]  core_rdata, gpr_wdata, gpr_rdata, sreg_wdata, mem_wdata, mem_rdata;
  logic        core_done, core_stall, gpr_we, sreg_we, mem_req, mem_we;
  logic [4:0]  gpr_idx;
  logic [23:0] mem_addr, pd, px, py, pz, pj;
  logic [15:0] sp_o;

  assign gpr_rdata = {gpr_idx, 3'b101};
  assign mem_rdata = mem_addr[7:0] ^ mem_addr[15:8] ^ 8'hC3;

  dspace_router dut_i (
    .clk(clk), .rst_n(rst_n), .core_req(core_req), .core_we(core_we),
    .core_addr(core_addr), .core_wdata(core_wdata), .core_rdata(core_rdata),
    .core_done(core_done), .core_stall(core_stall), .feat_straps(feat_straps),
    .gpr_idx(gpr_idx), .gpr_we(gpr_we), .gpr_wdata(gpr_wdata), .gpr_rdata(gpr_rdata),
    .sreg_rdata(sreg_rdata), .sreg_we(sreg_we), .sreg_wdata(sreg_wdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready), .page_d_o(pd), .page_x_o(px),
    .page_y_o(py), .page_z_o(pz), .jump_page_o(pj), .sp_o(sp_o)
  );

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [7:0]  m_ext [5];
  logic [15:0] m_sp;

  task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic int kind_of(input logic [15:0] a);
    if (a < 16'd32) return 0;
    if (a < 16'd88) return 2;
    if (a < 16'd96) return 1;
    return 3;
  endfunction

  function automatic logic [23:0] exp_bus(input logic [15:0] a);
    if (kind_of(a) == 2) return IO_B + 24'(a - 16'd32);
    return DATA_B + 24'(a);
  endfunction

  function automatic logic [7:0] exp_spec_rd(input int s);
    if (s < 5)  return m_ext[s];
    if (s == 5) return m_sp[7:0];
    if (s == 6) return m_sp[15:8];
    return sreg_rdata;
  endfunction

  task automatic check_regs(input string rq);
    chk(pd == {m_ext[0], 16'h0}, rq, pd, {m_ext[0], 16'h0});
    chk(px == {m_ext[1], 16'h0}, rq, px, {m_ext[1], 16'h0});
    chk(py == {m_ext[2], 16'h0}, rq, py, {m_ext[2], 16'h0});
    chk(pz == {m_ext[3], 16'h0}, rq, pz, {m_ext[3], 16'h0});
    chk(pj == {m_ext[4], 16'h0}, rq, pj, {m_ext[4], 16'h0});
    chk(sp_o == m_sp, rq, sp_o, m_sp);
  endtask

  task automatic access(input bit we, input logic [15:0] a, input logic [15:0] wd,
                        input logic [4:0] st, input int dly);
    int k = kind_of(a);
    int s = int'(a) - 88;
    @(negedge clk);
    core_req = 1; core_we = we; core_addr = a; core_wdata = wd;
    feat_straps = st; sreg_rdata = 8'($urandom);
    mem_ready = (dly == 0);
    #1;
    if (k >= 2) begin
      chk(mem_req == 1, k == 2 ? "R2" : "R3", mem_req, 1);
      chk(mem_addr == exp_bus(a), k == 2 ? "R2" : "R3", mem_addr, exp_bus(a));
      chk(mem_we == we, "R2", mem_we, we);
      if (we) chk(mem_wdata == wd[7:0], "R9", mem_wdata, wd[7:0]);
      for (int i = 0; i < dly; i++) begin
        chk(core_stall == 1 && core_done == 0, "R10", {core_stall, core_done}, 2'b10);
        @(negedge clk);
        if (i == dly - 1) mem_ready = 1;
        #1;
      end
      chk(core_done == 1 && core_stall == 0, "R10", {core_stall, core_done}, 2'b01);
      if (!we) chk(core_rdata == mem_rdata, "R10", core_rdata, mem_rdata);
    end else begin
      chk(core_done == 1 && core_stall == 0 && mem_req == 0, "R12",
          {core_done, core_stall, mem_req}, 3'b100);
      if (k == 0) begin
        chk(gpr_idx == a[4:0] && gpr_we == we, "R1", {gpr_we, gpr_idx}, {we, a[4:0]});
        if (we) chk(gpr_wdata == wd[7:0], "R9", gpr_wdata, wd[7:0]);
        else    chk(core_rdata == {a[4:0], 3'b101}, "R1", core_rdata, {a[4:0], 3'b101});
      end else begin
        chk(gpr_we == 0, "R1", gpr_we, 0);
        if (!we) chk(core_rdata == exp_spec_rd(s), s == 7 ? "R8" : "R4", core_rdata,
                     exp_spec_rd(s));
        chk(sreg_we == (we && s == 7), "R8", sreg_we, (we && s == 7));
        if (we && s == 7) chk(sreg_wdata == wd[7:0], "R8", sreg_wdata, wd[7:0]);
        if (we) begin
          if (s < 4 && st[s]) m_ext[s] = wd[7:0];
          if (s == 4) m_ext[4] = wd[7:0];
          if (s == 5) m_sp[7:0] = wd[7:0];
          if (s == 6 && st[4]) m_sp[15:8] = wd[7:0];
        end
      end
    end
    @(posedge clk); #1;
    core_req = 0; core_we = 0; mem_ready = 0;
    if (k == 1) check_regs(s < 4 ? "R4" : s == 4 ? "R5" : s == 5 ? "R6" : "R7");
  endtask

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 5; i++) m_ext[i] = 8'h00;
    m_sp = SP0;
    repeat (3) @(posedge clk);
    #1;
    check_regs("R11");
    chk(mem_req == 0 && core_stall == 0, "R11", {mem_req, core_stall}, 0);
    @(negedge clk); rst_n = 1;

    // boundaries of the three windows (R1, R2, R3)
    access(0, 16'd31, 0, 0, 0);
    access(0, 16'd32, 0, 0, 1);
    access(1, 16'd87, 16'h1234, 0, 2);
    access(0, 16'd96, 0, 0, 0);
    access(1, 16'hFFFF, 16'hAA55, 0, 3);
    // strap gating per data page (R4), jump page always (R5)
    for (int s = 0; s < 5; s++) begin
      access(1, 16'(88 + s), 16'hF0A0 + 16'(s), 5'h00, 0);
      access(0, 16'(88 + s), 0, 5'h00, 0);
      access(1, 16'(88 + s), 16'hE1B0 + 16'(s), 5'h1F, 0);
      access(0, 16'(88 + s), 0, 5'h00, 0);
    end
    // stack pointer halves (R6, R7), status port (R8), mask (R9)
    access(1, 16'd93, 16'hFF3C, 5'h1F, 0);
    access(1, 16'd94, 16'hEE77, 5'h00, 0);
    access(1, 16'd94, 16'hDD12, 5'h10, 0);
    access(0, 16'd94, 0, 0, 0);
    access(0, 16'd93, 0, 0, 0);
    access(1, 16'd95, 16'h9966, 0, 0);
    access(0, 16'd95, 0, 0, 0);
    access(1, 16'd5, 16'hBEEF, 0, 0);

    for (int n = 0; n < 600; n++) begin
      logic [15:0] a;
      int pick = $urandom_range(0, 3);
      case (pick)
        0: a = 16'($urandom_range(0, 31));
        1: a = 16'($urandom_range(32, 87));
        2: a = 16'($urandom_range(88, 95));
        default: a = 16'($urandom_range(96, 65535));
      endcase
      access(1'($urandom), a, 16'($urandom), 5'($urandom), $urandom_range(0, 3));
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog R10 actual=%0h expected=%0h", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule